// File: doc/BRIEF.md
# Programmable Baud Clock Divider

This block divides its input clock by a 16-bit divisor to produce a clock at sixteen times the serial bit rate, which a UART's transmit and receive shifters use. The divisor is held in two byte-wide latches that a host loads over a simple byte write port, one latch per write, picked by a select bit. As an example, with an input near 1.8462 MHz, a divisor of 12 gives 9600 baud and a divisor of 3 gives 38400 baud.

Two outputs are provided. The first is a waveform output with a fixed duty shape that depends on the divisor. The second is a one-cycle clock-enable strobe that fires once per output period, so that logic in the same clock domain can step without using the waveform as a clock. Any latch write restarts the count at once with the new divisor, so a stale large count never delays the first period. After reset the output idles high and the strobe stays low until the first latch write.

The write port is a plain control strobe with no back-pressure: a write takes effect on the clock edge where `wr_en` is high and is never refused. The byte write and the outputs carry no valid/ready handshake.

Top module: `baud_rate_gen`

## Requirements
- R1: After reset both latches are zero, `baud_o` is high and `tick_o` is low, and they stay that way until the first write.
- R2: A write with `wr_sel` = 0 loads divisor bits 7:0 and one with `wr_sel` = 1 loads bits 15:8. The other byte keeps its value.
- R3: In the clock cycle right after any write edge, a new period starts: `tick_o` is high and `baud_o` is low, whatever point the old count had reached.
- R4: For a divisor N of 3 or more, the period is N input cycles. `baud_o` is low in the first two cycles of the period and high in the remaining N-2.
- R5: A divisor of 0 gives a period of 3 cycles: low for 2 cycles, then high for 1.
- R6: A divisor of 2 gives a period of 2 cycles: low for 1 cycle, then high for 1.
- R7: A divisor of 1 makes `tick_o` high in every cycle, and `baud_o` is the inverse of `clk`.
- R8: `tick_o` is high for exactly one cycle per period. For every divisor other than 1, that cycle is the first low cycle of the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Latch write strobe, sampled on the rising edge |
| wr_sel | input | 1 | Latch select: 0 for the low byte, 1 for the high byte |
| wr_data | input | 8 | Byte to be written |
| baud_o | output | 1 | Divided waveform at sixteen times the bit rate |
| tick_o | output | 1 | One-cycle enable, once per output period |

## Verification
Every cycle, the assertions check the following:
- the idle state before the first write;
- the restart in the cycle after a write;
- the strobe falling in a low cycle;
- the second low cycle for divide-by-3 and larger divisors;
- the low/high alternation for divide-by-2;
- the strobe wrap at the end of a divide-by-3 period;
- the strobe in every cycle for a divisor of 1.

Only the bench scenarios show the following:
- the full period length for a given divisor, such as 12 or 261;
- how the two latch bytes combine;
- the waveform following the inverted clock in both clock phases for a divisor of 1.

// File: rtl/baudgen_pkg.sv
package baudgen_pkg;

  // Output shape families selected by the divisor value
  typedef enum logic [1:0] {
    BG_DIV3   = 2'd0,  // divisor zero: fixed divide by three
    BG_INVERT = 2'd1,  // divisor one: inverted input clock
    BG_HALF   = 2'd2,  // divisor two: 50% square wave
    BG_COUNT  = 2'd3   // divisor three or more: low two, high rest
  } bg_mode_e;

endpackage

// File: rtl/baudgen_latch.sv
module baudgen_latch #(
  parameter int DIV_W  = 16,
  parameter int BYTE_W = 8,
  localparam int LANES = DIV_W / BYTE_W,
  localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [DIV_W-1:0]  div_q,
  output logic [DIV_W-1:0]  div_next,
  output logic              load
);

  assign load = wr_en && (int'(wr_sel) < LANES);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic hit;
    assign hit = wr_en && (int'(wr_sel) == g);

    always_comb begin
      div_next[g*BYTE_W +: BYTE_W] = hit ? wr_data : div_q[g*BYTE_W +: BYTE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        div_q[g*BYTE_W +: BYTE_W] <= '0;
      end else if (hit) begin
        div_q[g*BYTE_W +: BYTE_W] <= wr_data;
      end
    end
  end

endmodule

// File: rtl/baudgen_count.sv
module baudgen_count #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] div_next,
  input  logic [DIV_W-1:0] div_q,
  output logic [DIV_W-1:0] cnt_q,
  output logic [DIV_W-1:0] last_idx,
  output logic             armed_q
);

  // Highest count value of one period: period length minus one
  function automatic logic [DIV_W-1:0] top_of(input logic [DIV_W-1:0] d);
    if (d == '0) begin
      return DIV_W'(2);
    end
    return d - DIV_W'(1);
  endfunction

  assign last_idx = top_of(div_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (load) begin
      cnt_q   <= top_of(div_next);
      armed_q <= 1'b1;
    end else if (armed_q) begin
      if (cnt_q == '0) begin
        cnt_q <= last_idx;
      end else begin
        cnt_q <= cnt_q - DIV_W'(1);
      end
    end
  end

endmodule

// File: rtl/baudgen_shape.sv
module baudgen_shape
  import baudgen_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             armed,
  input  logic [DIV_W-1:0] div_q,
  input  logic [DIV_W-1:0] cnt_q,
  input  logic [DIV_W-1:0] last_idx,
  output bg_mode_e         mode,
  output logic             baud_o,
  output logic             tick_o
);

  logic first_cyc;
  logic second_cyc;
  logic low_phase;

  always_comb begin
    if (div_q == DIV_W'(0)) begin
      mode = BG_DIV3;
    end else if (div_q == DIV_W'(1)) begin
      mode = BG_INVERT;
    end else if (div_q == DIV_W'(2)) begin
      mode = BG_HALF;
    end else begin
      mode = BG_COUNT;
    end
  end

  assign first_cyc  = (cnt_q == last_idx);
  assign second_cyc = (mode == BG_COUNT || mode == BG_DIV3) &&
                      (cnt_q == last_idx - DIV_W'(1));
  assign low_phase  = first_cyc || second_cyc;

  assign tick_o = armed && first_cyc;

  always_comb begin
    if (!armed) begin
      baud_o = 1'b1;
    end else if (mode == BG_INVERT) begin
      baud_o = ~clk;
    end else begin
      baud_o = ~low_phase;
    end
  end

endmodule

// File: rtl/baud_rate_gen.sv
module baud_rate_gen
  import baudgen_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  output logic       baud_o,
  output logic       tick_o
);

  localparam int DIV_W  = 16;
  localparam int BYTE_W = 8;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_next;
  logic             load;
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] last_idx;
  logic             armed_q;
  bg_mode_e         mode;

  baudgen_latch #(.DIV_W(DIV_W), .BYTE_W(BYTE_W)) latch_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .div_q    (div_q),
    .div_next (div_next),
    .load     (load)
  );

  baudgen_count #(.DIV_W(DIV_W)) count_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .div_next (div_next),
    .div_q    (div_q),
    .cnt_q    (cnt_q),
    .last_idx (last_idx),
    .armed_q  (armed_q)
  );

  baudgen_shape #(.DIV_W(DIV_W)) shape_i (
    .clk      (clk),
    .armed    (armed_q),
    .div_q    (div_q),
    .cnt_q    (cnt_q),
    .last_idx (last_idx),
    .mode     (mode),
    .baud_o   (baud_o),
    .tick_o   (tick_o)
  );

endmodule

// File: rtl/baud_rate_gen_chk.sv
module baud_rate_gen_chk
  import baudgen_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input logic     load,
  input logic     armed,
  input bg_mode_e mode,
  input logic     baud_o,
  input logic     tick_o
);

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (baud_o && !tick_o));

  // R3
  restart_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> tick_o);

  // R8
  tick_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && mode != BG_INVERT) |-> !baud_o);

  // R4
  second_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && !load && (mode == BG_COUNT || mode == BG_DIV3)) |=> (!baud_o && !tick_o));

  // R6
  half_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && !load && mode == BG_HALF) |=> (baud_o && !tick_o));

  // R5
  div3_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && mode == BG_DIV3 && baud_o && !load) |=> tick_o);

  // R7
  invert_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && mode == BG_INVERT) |-> tick_o);

endmodule

bind baud_rate_gen baud_rate_gen_chk chk_i (
  .clk    (clk),
  .rst_n  (rst_n),
  .load   (load),
  .armed  (armed_q),
  .mode   (mode),
  .baud_o (baud_o),
  .tick_o (tick_o)
);

// File: tb/baud_rate_gen_tb_top.sv
module baud_rate_gen_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       baud_o;
  logic       tick_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  baud_rate_gen dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .baud_o  (baud_o),
    .tick_o  (tick_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Ends one clock after the write edge, 1 ns past the falling edge
  task automatic write_byte(input bit sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_sel = sel;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  // Compares the waveform and strobe against the expected shape for period n
  task automatic run_pattern(input int n, input int cycles, input string req);
    for (int i = 0; i < cycles; i++) begin
      int ph = i % n;
      bit exp_tick = (ph == 0);
      bit exp_out = (n == 2) ? (ph != 0) : (ph >= 2);
      check(tick_o == exp_tick, req, "tick", int'(tick_o), int'(exp_tick));
      check(baud_o == exp_out, req, "baud", int'(baud_o), int'(exp_out));
      @(negedge clk);
      #1;
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    for (int i = 0; i < 10; i++) begin
      check(baud_o == 1'b1, "R1", "idle baud", int'(baud_o), 1);
      check(tick_o == 1'b0, "R1", "idle tick", int'(tick_o), 0);
      @(negedge clk);
      #1;
    end
  endtask

  task automatic t_div12;
    write_byte(1'b1, 8'h00);
    write_byte(1'b0, 8'd12);
    run_pattern(12, 40, "R4");
  endtask

  task automatic t_div3;
    write_byte(1'b0, 8'd3);
    run_pattern(3, 12, "R4");
  endtask

  task automatic t_div0;
    write_byte(1'b0, 8'd0);
    run_pattern(3, 12, "R5");
  endtask

  task automatic t_div2;
    write_byte(1'b0, 8'd2);
    run_pattern(2, 10, "R6");
  endtask

  task automatic t_div1;
    write_byte(1'b0, 8'd1);
    for (int i = 0; i < 8; i++) begin
      check(tick_o == 1'b1, "R7", "tick low phase", int'(tick_o), 1);
      check(baud_o == 1'b1, "R7", "baud low phase", int'(baud_o), 1);
      @(posedge clk);
      #1;
      check(tick_o == 1'b1, "R7", "tick high phase", int'(tick_o), 1);
      check(baud_o == 1'b0, "R7", "baud high phase", int'(baud_o), 0);
      @(negedge clk);
      #1;
    end
  endtask

  task automatic t_reload;
    write_byte(1'b0, 8'd200);
    repeat (37) begin
      @(negedge clk);
      #1;
    end
    check(tick_o == 1'b0, "R3", "mid-period tick", int'(tick_o), 0);
    write_byte(1'b0, 8'd10);
    check(tick_o == 1'b1, "R3", "tick after write", int'(tick_o), 1);
    check(baud_o == 1'b0, "R3", "baud after write", int'(baud_o), 0);
    run_pattern(10, 30, "R3");
  endtask

  task automatic t_high_byte;
    // After this high write the divisor is 0x010A; the low byte keeps 10
    write_byte(1'b1, 8'h01);
    run_pattern(266, 540, "R2");
    write_byte(1'b0, 8'h05);
    run_pattern(261, 530, "R2");
  endtask

  task automatic t_single_tick;
    int ticks = 0;
    write_byte(1'b1, 8'h00);
    write_byte(1'b0, 8'd7);
    for (int i = 0; i < 70; i++) begin
      if (tick_o) ticks++;
      @(negedge clk);
      #1;
    end
    check(ticks == 10, "R8", "ticks in 70 cycles", ticks, 10);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_div12();
    t_div3();
    t_div0();
    t_div2();
    t_div1();
    t_reload();
    t_high_byte();
    t_single_tick();
    finish_run();
  end

  initial begin
    #(8 * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule